// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block sits beside an Ethernet MAC and records the value of the free-running time counter at the moment a frame that needs a precision-time stamp starts to pass. It keeps one capture slot for the transmit direction and one for the receive direction. Each slot holds a single 64-bit time value, a valid flag and a lock. Once a slot has captured, it refuses all further captures until software reads the upper word of that slot. A capture that arrives while the slot is locked is dropped and recorded in a sticky missed-capture flag.

Transmit captures happen on a start-of-frame strobe that the transmit path marks as wanting a stamp. Only one such frame should be outstanding, and software polls the transmit valid flag to learn that its capture has completed. Receive captures use a start-of-frame strobe and two hit lines from an upstream packet classifier: one for a layer-2 frame with Ethernet type 0x88F7, one for a UDP frame to the event port. A two-bit filter mode chooses which frames qualify. Software reads a slot as low word then high word, and the high-word read releases the lock.

Top module: `pkt_stamp_latch`

## Requirements
- R1: After reset every slot is empty: valid and missed flags read 0, the read data output is 0, and the control word shows only the enable inputs (bit 0 transmit enable, bit 4 receive enable).
- R2: With its enable high and its slot not valid, a qualifying start-of-frame sets the slot's valid flag on that clock edge and stores the time input present at that edge.
- R3: While a slot is valid its stored time does not change, whatever frames arrive.
- R4: A qualifying start-of-frame that arrives while the slot is valid is dropped and sets that slot's missed flag, which stays set until cleared per R7 or R10.
- R5: A read of a slot's high word (address 2 transmit, address 4 receive) clears that slot's valid flag on the same edge; a read of the low word (address 1 transmit, address 3 receive) leaves it valid. Reading all four words releases both slots.
- R6: Reads take one cycle: rd_data shows the addressed word on the edge after rd_en is high and holds until the next read. Address 0 is the control word (bit 1 transmit valid, bit 2 transmit missed, bit 5 receive valid, bit 6 receive missed); addresses 1 and 2 are the transmit time's low and high 32 bits, addresses 3 and 4 the receive time's.
- R7: While a direction's enable is low its valid and missed flags are cleared and no capture is made.
- R8: Receive frames qualify by rx_mode: 0 every frame, 1 only with rx_hit_l2, 2 only with rx_hit_l4, 3 with either hit.
- R9: A transmit start-of-frame qualifies only when tx_stamp_req is high at the same edge.
- R10: Reading the control word clears both missed flags, except that a miss arriving on the same edge sets its flag.
- R11: Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | 64 | Current value of the time counter |
| tx_en | input | 1 | Transmit capture enable |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_stamp_req | input | 1 | Current transmit frame wants a stamp |
| rx_en | input | 1 | Receive capture enable |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_mode | input | 2 | Receive filter mode |
| rx_hit_l2 | input | 1 | Classifier: layer-2 event frame |
| rx_hit_l4 | input | 1 | Classifier: UDP event-port frame |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Word address of the read |
| rd_data | output | 32 | Read data, registered |

## Verification
A slot whose lock fails to hold would show as a changed time value in the very next read of that slot, and a lock that fails to release would leave the valid bit at 1 in the control word read directly after the high-word read. Wrong filter decoding shows as a valid bit that differs from expectation one read after a single receive strobe, and a missed flag that is never set or never cleared shows in the next control-word read. The random phase reads every word often enough that any divergence of the slot state appears within a handful of cycles.

// File: rtl/pkt_stamp_pkg.sv
// Shared definitions for the packet timestamp latch: word map of the
// read port, control-word bit positions and receive filter modes.
package pkt_stamp_pkg;

    localparam int unsigned NUM_DIR = 2;
    localparam int unsigned DIR_TX  = 0;
    localparam int unsigned DIR_RX  = 1;

    typedef enum logic [2:0] {
        WA_CTRL  = 3'd0,
        WA_TX_LO = 3'd1,
        WA_TX_HI = 3'd2,
        WA_RX_LO = 3'd3,
        WA_RX_HI = 3'd4
    } word_addr_e;

    localparam int unsigned CB_TX_EN   = 0;
    localparam int unsigned CB_TX_VAL  = 1;
    localparam int unsigned CB_TX_MISS = 2;
    localparam int unsigned CB_RX_EN   = 4;
    localparam int unsigned CB_RX_VAL  = 5;
    localparam int unsigned CB_RX_MISS = 6;

    typedef enum logic [1:0] {
        RXF_ALL   = 2'd0,
        RXF_L2    = 2'd1,
        RXF_L4    = 2'd2,
        RXF_EVENT = 2'd3
    } rx_filter_e;

endpackage

// File: rtl/stamp_rx_qual.sv
// Receive qualifier: decides whether a receive start-of-frame asks for a
// capture, given the filter mode and the classifier hit lines.
// Assumes the hit lines are valid in the same cycle as the strobe.
module stamp_rx_qual
    import pkt_stamp_pkg::*;
(
    input  logic       sof,
    input  logic [1:0] mode,
    input  logic       hit_l2,
    input  logic       hit_l4,
    output logic       req
);

    rx_filter_e mode_e;
    logic       pass;

    // Decode the filter mode into a pass decision.
    always_comb begin
        mode_e = rx_filter_e'(mode);
        case (mode_e)
            RXF_ALL:   pass = 1'b1;
            RXF_L2:    pass = hit_l2;
            RXF_L4:    pass = hit_l4;
            RXF_EVENT: pass = hit_l2 | hit_l4;
            default:   pass = 1'b0;
        endcase
    end

    // A capture is requested only on a start-of-frame that passes.
    assign req = sof & pass;

endmodule

// File: rtl/stamp_slot.sv
// One capture slot: stores the time on a request when empty, then locks
// until released; requests while locked set a sticky missed flag.
// Assumes release and clr_missed are single-cycle read-side pulses.
module stamp_slot #(
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              req,
    input  logic [TIME_W-1:0] time_now,
    input  logic              release_i,
    input  logic              clr_missed,
    output logic              valid,
    output logic              missed,
    output logic [TIME_W-1:0] ts
);

    logic take;
    logic lost;

    assign take = en & req & ~valid;
    assign lost = en & req & valid;

    // Capture, lock and release of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            ts    <= '0;
        end else if (!en) begin
            valid <= 1'b0;
        end else if (take) begin
            valid <= 1'b1;
            ts    <= time_now;
        end else if (release_i) begin
            valid <= 1'b0;
        end
    end

    // Sticky record of captures dropped while locked.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            missed <= 1'b0;
        end else if (lost) begin
            missed <= 1'b1;
        end else if (clr_missed) begin
            missed <= 1'b0;
        end
    end

    // R2: an empty enabled slot captures the current time.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        en && req && !valid |=> valid && ts == $past(time_now));

    // R3: a locked slot keeps its stored time.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        en && valid |=> ts == $past(ts));

    // R4: a request against a locked slot marks a miss.
    a_r4_miss: assert property (@(posedge clk) disable iff (!rst_n)
        en && req && valid |=> missed);

    // R5: releasing a locked slot empties it.
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        en && valid && release_i |=> !valid);

    // R7: a disabled slot holds no capture and no miss.
    a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !valid && !missed);

endmodule

// File: rtl/stamp_rdport.sv
// Registered 32-bit read port: selects the addressed word and produces
// the release and missed-clear pulses that reads cause.
// Assumes the time value is exactly two data words wide.
module stamp_rdport
    import pkt_stamp_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TIME_W = 64,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [TIME_W-1:0] ts_tx,
    input  logic [TIME_W-1:0] ts_rx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rel_tx,
    output logic              rel_rx,
    output logic              clr_missed
);

    localparam int unsigned HI_LSB = TIME_W - DATA_W;

    word_addr_e        addr_e;
    logic [DATA_W-1:0] word_sel;

    // Select the word that the address names.
    always_comb begin
        addr_e = word_addr_e'(rd_addr);
        case (addr_e)
            WA_CTRL:  word_sel = ctrl_word;
            WA_TX_LO: word_sel = ts_tx[DATA_W-1:0];
            WA_TX_HI: word_sel = ts_tx[TIME_W-1:HI_LSB];
            WA_RX_LO: word_sel = ts_rx[DATA_W-1:0];
            WA_RX_HI: word_sel = ts_rx[TIME_W-1:HI_LSB];
            default:  word_sel = '0;
        endcase
    end

    // Side effects of a read.
    assign rel_tx     = rd_en && (addr_e == WA_TX_HI);
    assign rel_rx     = rd_en && (addr_e == WA_RX_HI);
    assign clr_missed = rd_en && (addr_e == WA_CTRL);

    // Register the read data; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= word_sel;
        end
    end

    // R11: addresses past the map read as zero.
    a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr > ADDR_W'(WA_RX_HI) |=> rd_data == '0);

    // R6: read data is stable when no read is issued.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/pkt_stamp_latch.sv
// Packet timestamp latch top: one transmit and one receive capture slot,
// receive filtering, and the register read port.
// Assumes strobes are single-cycle and synchronous to clk.
module pkt_stamp_latch
    import pkt_stamp_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_now,
    input  logic              tx_en,
    input  logic              tx_sof,
    input  logic              tx_stamp_req,
    input  logic              rx_en,
    input  logic              rx_sof,
    input  logic [1:0]        rx_mode,
    input  logic              rx_hit_l2,
    input  logic              rx_hit_l4,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_DIR-1:0] slot_en;
    logic [NUM_DIR-1:0] slot_req;
    logic [NUM_DIR-1:0] slot_rel;
    logic [NUM_DIR-1:0] slot_valid;
    logic [NUM_DIR-1:0] slot_missed;
    logic [TIME_W-1:0]  slot_ts [NUM_DIR];
    logic               rx_req;
    logic               rel_tx;
    logic               rel_rx;
    logic               clr_missed;
    logic [DATA_W-1:0]  ctrl_word;

    // Receive frame qualification.
    stamp_rx_qual u_rx_qual (
        .sof    (rx_sof),
        .mode   (rx_mode),
        .hit_l2 (rx_hit_l2),
        .hit_l4 (rx_hit_l4),
        .req    (rx_req)
    );

    // Per-direction enables, requests and releases.
    assign slot_en[DIR_TX]  = tx_en;
    assign slot_en[DIR_RX]  = rx_en;
    assign slot_req[DIR_TX] = tx_sof & tx_stamp_req;
    assign slot_req[DIR_RX] = rx_req;
    assign slot_rel[DIR_TX] = rel_tx;
    assign slot_rel[DIR_RX] = rel_rx;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_slot
        stamp_slot #(.TIME_W(TIME_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (slot_en[d]),
            .req        (slot_req[d]),
            .time_now   (time_now),
            .release_i  (slot_rel[d]),
            .clr_missed (clr_missed),
            .valid      (slot_valid[d]),
            .missed     (slot_missed[d]),
            .ts         (slot_ts[d])
        );
    end

    // Assemble the control/status word.
    always_comb begin
        ctrl_word             = '0;
        ctrl_word[CB_TX_EN]   = tx_en;
        ctrl_word[CB_TX_VAL]  = slot_valid[DIR_TX];
        ctrl_word[CB_TX_MISS] = slot_missed[DIR_TX];
        ctrl_word[CB_RX_EN]   = rx_en;
        ctrl_word[CB_RX_VAL]  = slot_valid[DIR_RX];
        ctrl_word[CB_RX_MISS] = slot_missed[DIR_RX];
    end

    // Register read port.
    stamp_rdport #(
        .DATA_W (DATA_W),
        .TIME_W (TIME_W),
        .ADDR_W (ADDR_W)
    ) u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .ctrl_word  (ctrl_word),
        .ts_tx      (slot_ts[DIR_TX]),
        .ts_rx      (slot_ts[DIR_RX]),
        .rd_data    (rd_data),
        .rel_tx     (rel_tx),
        .rel_rx     (rel_rx),
        .clr_missed (clr_missed)
    );

    // R9: a transmit strobe without a stamp request never fills an empty slot.
    a_r9_txqual: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && !slot_valid[DIR_TX] && !(tx_sof && tx_stamp_req)
        |=> !slot_valid[DIR_TX]);

    // R8: in layer-2 mode a strobe without the layer-2 hit is not captured.
    a_r8_l2only: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && !slot_valid[DIR_RX] && rx_mode == 2'd1 && !rx_hit_l2
        |=> !slot_valid[DIR_RX]);

endmodule

// File: tb/pkt_stamp_latch_test.sv
`timescale 1ns/1ps
module pkt_stamp_latch_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] time_now;
    logic        tx_en, tx_sof, tx_stamp_req;
    logic        rx_en, rx_sof, rx_hit_l2, rx_hit_l4;
    logic [1:0]  rx_mode;
    logic        rd_en;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;

    // Reference model state
    logic        m_valid [2];
    logic        m_miss  [2];
    logic [63:0] m_ts    [2];
    logic [31:0] m_rd;

    pkt_stamp_latch uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .time_now     (time_now),
        .tx_en        (tx_en),
        .tx_sof       (tx_sof),
        .tx_stamp_req (tx_stamp_req),
        .rx_en        (rx_en),
        .rx_sof       (rx_sof),
        .rx_mode      (rx_mode),
        .rx_hit_l2    (rx_hit_l2),
        .rx_hit_l4    (rx_hit_l4),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] model_ctrl();
        logic [31:0] w = '0;
        w[0] = tx_en; w[1] = m_valid[0]; w[2] = m_miss[0];
        w[4] = rx_en; w[5] = m_valid[1]; w[6] = m_miss[1];
        return w;
    endfunction

    function automatic logic [31:0] model_word(input logic [2:0] a);
        case (a)
            3'd0: return model_ctrl();
            3'd1: return m_ts[0][31:0];
            3'd2: return m_ts[0][63:32];
            3'd3: return m_ts[1][31:0];
            3'd4: return m_ts[1][63:32];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic rx_pass();
        case (rx_mode)
            2'd0: return 1'b1;
            2'd1: return rx_hit_l2;
            2'd2: return rx_hit_l4;
            default: return rx_hit_l2 | rx_hit_l4;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance one clock, updating the model from the driven inputs.
    task automatic cycle(input string tag);
        logic rq [2];
        logic en [2];
        logic rel [2];
        logic clr;
        logic did_rd;
        rq[0]  = tx_sof & tx_stamp_req;
        rq[1]  = rx_sof & rx_pass();
        en[0]  = tx_en;
        en[1]  = rx_en;
        rel[0] = rd_en && rd_addr == 3'd2;
        rel[1] = rd_en && rd_addr == 3'd4;
        clr    = rd_en && rd_addr == 3'd0;
        did_rd = rd_en;
        if (!rst_n) begin
            m_rd = '0;
            for (int d = 0; d < 2; d++) begin
                m_valid[d] = 1'b0; m_miss[d] = 1'b0; m_ts[d] = '0;
            end
        end else begin
            if (rd_en) m_rd = model_word(rd_addr);
            for (int d = 0; d < 2; d++) begin
                if (!en[d]) begin
                    m_valid[d] = 1'b0; m_miss[d] = 1'b0;
                end else begin
                    logic v_old = m_valid[d];
                    if (rq[d] && !v_old) begin
                        m_valid[d] = 1'b1; m_ts[d] = time_now;
                    end else if (rel[d]) begin
                        m_valid[d] = 1'b0;
                    end
                    if (rq[d] && v_old) m_miss[d] = 1'b1;
                    else if (clr) m_miss[d] = 1'b0;
                end
            end
        end
        @(posedge clk);
        #1;
        if (did_rd && rst_n) chk(tag, rd_data, m_rd);
    endtask

    task automatic idle();
        tx_sof = 0; tx_stamp_req = 0; rx_sof = 0; rx_hit_l2 = 0; rx_hit_l4 = 0;
        rd_en = 0; rd_addr = 0;
        time_now = {$urandom, $urandom};
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        rd_en = 1; rd_addr = a;
        cycle(tag);
        idle();
    endtask

    task automatic tx_frame(input logic want);
        tx_sof = 1; tx_stamp_req = want;
        cycle("R9");
        idle();
    endtask

    task automatic rx_frame(input logic l2, input logic l4);
        rx_sof = 1; rx_hit_l2 = l2; rx_hit_l4 = l4;
        cycle("R8");
        idle();
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0; tx_en = 1; rx_en = 1; rx_mode = 0;
        idle();
        #1;
        repeat (3) cycle("R1");
        rst_n = 1;
        chk("R1 rd_data after reset", rd_data, 32'd0);
        rd(3'd0, "R1 ctrl after reset");
        chk("R1 empty ctrl", rd_data, 32'h0000_0011);

        // R9: strobe without stamp request
        tx_frame(1'b0);
        rd(3'd0, "R9 no capture");
        chk("R9 tx valid clear", rd_data, 32'h0000_0011);

        // R2: capture
        tx_sof = 1; tx_stamp_req = 1; time_now = 64'h1122_3344_5566_7788;
        cycle("R2"); idle();
        rd(3'd0, "R2 ctrl");
        chk("R2 tx valid", rd_data, 32'h0000_0013);
        // R4 / R3: second request while locked
        tx_frame(1'b1);
        rd(3'd1, "R3 low word held");
        chk("R3 tx low", rd_data, 32'h5566_7788);
        rd(3'd0, "R5 low read keeps lock");
        chk("R4 missed set, R5 still valid", rd_data, 32'h0000_0017);
        rd(3'd0, "R10 missed cleared");
        chk("R10 ctrl after clear", rd_data, 32'h0000_0013);
        rd(3'd2, "R3 high word");
        chk("R3 tx high", rd_data, 32'h1122_3344);
        rd(3'd0, "R5 released");
        chk("R5 tx released", rd_data, 32'h0000_0011);

        // R10: miss on same edge as control read wins
        tx_frame(1'b1);
        tx_sof = 1; tx_stamp_req = 1; rd_en = 1; rd_addr = 0;
        cycle("R10 same-edge read"); idle();
        rd(3'd0, "R10 set wins");
        chk("R10 miss kept", rd_data, 32'h0000_0017);

        // R7: disable clears
        tx_en = 0; cycle("R7"); tx_en = 1;
        rd(3'd0, "R7 after disable");
        chk("R7 tx cleared", rd_data, 32'h0000_0011);
        tx_en = 0; tx_frame(1'b1); tx_en = 1;
        rd(3'd0, "R7 no capture when off");

        // R8: every filter mode against every hit pattern
        for (int md = 0; md < 4; md++) begin
            for (int h = 0; h < 4; h++) begin
                rx_mode = md[1:0];
                rx_frame(h[0], h[1]);
                rd(3'd0, "R8 filter");
                rd(3'd3, "R8 rx low");
                rd(3'd4, "R5 rx release");
            end
        end

        // R5: read all four words releases both slots
        rx_mode = 0;
        tx_sof = 1; tx_stamp_req = 1; rx_sof = 1; cycle("R2 both"); idle();
        for (int a = 1; a <= 4; a++) rd(a[2:0], "R5 four words");
        rd(3'd0, "R5 both released");
        chk("R5 both empty", rd_data, 32'h0000_0011);

        // R11: unmapped addresses
        for (int a = 5; a < 8; a++) begin
            rd(a[2:0], "R11 unmapped");
            chk("R11 zero", rd_data, 32'd0);
        end

        // R6: random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            tx_en        = ($urandom_range(0, 19) != 0);
            rx_en        = ($urandom_range(0, 19) != 0);
            tx_sof       = ($urandom_range(0, 5) == 0);
            tx_stamp_req = $urandom_range(0, 1);
            rx_sof       = ($urandom_range(0, 4) == 0);
            rx_hit_l2    = $urandom_range(0, 1);
            rx_hit_l4    = $urandom_range(0, 1);
            rx_mode      = 2'($urandom_range(0, 3));
            rd_en        = ($urandom_range(0, 2) == 0);
            rd_addr      = 3'($urandom_range(0, 7));
            time_now     = {$urandom, $urandom};
            cycle("R6 random");
        end
        idle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule